// File: doc/BRIEF.md
# Multi-Mode GPIO Controller

A 32-pin general-purpose I/O block on a simple register bus. Software drives an output latch through two write-one-only registers, one that raises bits and one that lowers them, so a driver can change a few pins without a read-modify-write sequence. Each pin has a 2-bit drive mode, packed sixteen to a word across two mode registers. The modes are input, push-pull output, open-drain and open-source. An alternate-function select register hands any pin to a peripheral, whose output-enable and output value then go straight to the pad.

Pad inputs pass through a two-flop synchronizer before software can read them. The block drives one output-enable and one output-value line per pad. Pad electrical behaviour is left to the pad ring. Bus reads are registered.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After reset the output latch, both mode registers and the alternate-function select register are zero: every pin is an input with pad_oe and pad_out low, and reads of these registers return 0.
- R2: A read request (bus_req high, bus_wr low) loads bus_rdata at the clock edge that samples it. bus_rdata keeps its value through cycles that carry no read request.
- R3: A write to offset 0x04 sets every latch bit whose wdata bit is 1 and leaves the other bits alone. Reads of offset 0x04 or 0x08 return the latch.
- R4: A write to offset 0x08 clears every latch bit whose wdata bit is 1 and leaves the other bits alone.
- R5: Offset 0x0C holds the modes of pins 0-15 and offset 0x10 those of pins 16-31. Pin n uses bits [2*(n%16)+1 : 2*(n%16)]. Both registers read back as written.
- R6: Mode 0 (input): pad_oe is 0 and pad_out is 0.
- R7: Mode 1 (push-pull): pad_oe is 1 and pad_out equals the latch bit.
- R8: Mode 2 (open-drain): pad_out is 0 and pad_oe is 1 only while the latch bit is 0.
- R9: Mode 3 (open-source): pad_out is 1 and pad_oe is 1 only while the latch bit is 1.
- R10: When bit n of offset 0x14 is 1, pad_oe[n] and pad_out[n] follow alt_oe[n] and alt_out[n], whatever the mode and latch are. Offset 0x14 reads back as written.
- R11: Offset 0x00 returns pad_in through two synchronizer flops. A pad value held from clock edge k is returned by reads sampled at edge k+2 or later. A read sampled at edge k+1 still returns the earlier value.
- R12: Offset 0x18 reads the current pad_out vector. Writes to 0x00, 0x18 and any unmapped offset change nothing, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_oe | output | 32 | Pad output enables |
| pad_out | output | 32 | Pad output values |
| alt_oe | input | 32 | Output enables from alternate-function peripherals |
| alt_out | input | 32 | Output values from alternate-function peripherals |

## Verification
A register write takes effect at the edge that samples it, so pad_oe and pad_out are checked half a cycle after that edge. Read data is checked half a cycle after the edge that samples the request. The input path is checked by reads sampled one and two edges after a pad change. The first read must still return the old value and the second the new one, which pins the synchronizer depth exactly. The drive-mode table writes modes and latch values, then reads the pads only after the last write of each vector has been clocked in.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

   localparam int MODE_W = 2;

   localparam int OFF_INPUT   = 'h00;
   localparam int OFF_SET     = 'h04;
   localparam int OFF_CLR     = 'h08;
   localparam int OFF_MODE_LO = 'h0C;
   localparam int OFF_MODE_HI = 'h10;
   localparam int OFF_ALT_SEL = 'h14;
   localparam int OFF_ALT_VAL = 'h18;

   typedef enum logic [MODE_W-1:0] {
      PM_INPUT       = 2'd0,
      PM_PUSH_PULL   = 2'd1,
      PM_OPEN_DRAIN  = 2'd2,
      PM_OPEN_SOURCE = 2'd3
   } pin_mode_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_mux_pkg::*;
#(
   parameter int PIN_COUNT = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_req,
   input  logic                        bus_wr,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   input  logic [PIN_COUNT-1:0]        in_sync,
   input  logic [PIN_COUNT-1:0]        pad_out_view,
   output logic [PIN_COUNT-1:0]        out_latch,
   output logic [PIN_COUNT-1:0]        alt_sel,
   output logic [MODE_W*PIN_COUNT-1:0] mode_flat
);

   localparam int FIELDS_PER_REG = DATA_W / MODE_W;
   localparam int MODE_REGS      = (PIN_COUNT + FIELDS_PER_REG - 1) / FIELDS_PER_REG;

   if (PIN_COUNT > DATA_W) begin : g_bad_pins
      $error("gpio_regbank: PIN_COUNT exceeds DATA_W");
   end
   if (MODE_REGS > 2) begin : g_bad_mode_regs
      $error("gpio_regbank: pins do not fit the two mode registers");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("gpio_regbank: ADDR_W too narrow for the register map");
   end

   logic wr_cyc, rd_cyc;
   logic wr_set, wr_clr, wr_alt;
   logic [1:0] wr_mode;

   assign wr_cyc     = bus_req && bus_wr;
   assign rd_cyc     = bus_req && !bus_wr;
   assign wr_set     = wr_cyc && (bus_addr == ADDR_W'(OFF_SET));
   assign wr_clr     = wr_cyc && (bus_addr == ADDR_W'(OFF_CLR));
   assign wr_alt     = wr_cyc && (bus_addr == ADDR_W'(OFF_ALT_SEL));
   assign wr_mode[0] = wr_cyc && (bus_addr == ADDR_W'(OFF_MODE_LO));
   assign wr_mode[1] = wr_cyc && (bus_addr == ADDR_W'(OFF_MODE_HI));

   // Output latch: set and clear masks merge, clear applied last.
   logic [PIN_COUNT-1:0] set_mask, clr_mask, latch_d;

   always_comb begin
      set_mask = wr_set ? bus_wdata[PIN_COUNT-1:0] : '0;
      clr_mask = wr_clr ? bus_wdata[PIN_COUNT-1:0] : '0;
      latch_d  = (out_latch | set_mask) & ~clr_mask;
   end

   // Mode fields: each pin takes its slice from whichever word covers it.
   logic [MODE_W*PIN_COUNT-1:0] mode_d;

   always_comb begin
      mode_d = mode_flat;
      for (int p = 0; p < PIN_COUNT; p++) begin
         if (wr_mode[p / FIELDS_PER_REG]) begin
            mode_d[MODE_W*p +: MODE_W] = bus_wdata[MODE_W*(p % FIELDS_PER_REG) +: MODE_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_latch <= '0;
         mode_flat <= '0;
         alt_sel   <= '0;
      end else begin
         out_latch <= latch_d;
         mode_flat <= mode_d;
         if (wr_alt) alt_sel <= bus_wdata[PIN_COUNT-1:0];
      end
   end

   // Read path.
   logic [DATA_W-1:0] mode_word [2];
   logic [DATA_W-1:0] rd_word;

   always_comb begin
      mode_word[0] = '0;
      mode_word[1] = '0;
      for (int p = 0; p < PIN_COUNT; p++) begin
         mode_word[p / FIELDS_PER_REG][MODE_W*(p % FIELDS_PER_REG) +: MODE_W] =
            mode_flat[MODE_W*p +: MODE_W];
      end
   end

   always_comb begin
      rd_word = '0;
      case (bus_addr)
         ADDR_W'(OFF_INPUT):   rd_word = DATA_W'(in_sync);
         ADDR_W'(OFF_SET),
         ADDR_W'(OFF_CLR):     rd_word = DATA_W'(out_latch);
         ADDR_W'(OFF_MODE_LO): rd_word = mode_word[0];
         ADDR_W'(OFF_MODE_HI): rd_word = mode_word[1];
         ADDR_W'(OFF_ALT_SEL): rd_word = DATA_W'(alt_sel);
         ADDR_W'(OFF_ALT_VAL): rd_word = DATA_W'(pad_out_view);
         default:              rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_cyc) bus_rdata <= rd_word;
   end

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
   import gpio_mux_pkg::*;
#(
   parameter int PIN_COUNT = 32
) (
   input  logic [MODE_W*PIN_COUNT-1:0] mode_flat,
   input  logic [PIN_COUNT-1:0]        out_latch,
   input  logic [PIN_COUNT-1:0]        alt_sel,
   input  logic [PIN_COUNT-1:0]        alt_oe,
   input  logic [PIN_COUNT-1:0]        alt_out,
   output logic [PIN_COUNT-1:0]        pad_oe,
   output logic [PIN_COUNT-1:0]        pad_out
);

   for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
      pin_mode_e mode;
      logic      gp_oe, gp_out;

      assign mode = pin_mode_e'(mode_flat[MODE_W*p +: MODE_W]);

      always_comb begin
         case (mode)
            PM_PUSH_PULL: begin
               gp_oe  = 1'b1;
               gp_out = out_latch[p];
            end
            PM_OPEN_DRAIN: begin
               gp_oe  = ~out_latch[p];
               gp_out = 1'b0;
            end
            PM_OPEN_SOURCE: begin
               gp_oe  = out_latch[p];
               gp_out = 1'b1;
            end
            default: begin
               gp_oe  = 1'b0;
               gp_out = 1'b0;
            end
         endcase
      end

      assign pad_oe[p]  = alt_sel[p] ? alt_oe[p]  : gp_oe;
      assign pad_out[p] = alt_sel[p] ? alt_out[p] : gp_out;
   end

endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
   import gpio_mux_pkg::*;
#(
   parameter int PIN_COUNT   = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_req,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [PIN_COUNT-1:0] pad_in,
   output logic [PIN_COUNT-1:0] pad_oe,
   output logic [PIN_COUNT-1:0] pad_out,
   input  logic [PIN_COUNT-1:0] alt_oe,
   input  logic [PIN_COUNT-1:0] alt_out
);

   logic [PIN_COUNT-1:0]        in_sync;
   logic [PIN_COUNT-1:0]        out_latch;
   logic [PIN_COUNT-1:0]        alt_sel;
   logic [MODE_W*PIN_COUNT-1:0] mode_flat;

   gpio_in_sync #(
      .WIDTH  (PIN_COUNT),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (in_sync)
   );

   gpio_regbank #(
      .PIN_COUNT (PIN_COUNT),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_req      (bus_req),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .in_sync      (in_sync),
      .pad_out_view (pad_out),
      .out_latch    (out_latch),
      .alt_sel      (alt_sel),
      .mode_flat    (mode_flat)
   );

   gpio_pin_drive #(
      .PIN_COUNT (PIN_COUNT)
   ) u_drive (
      .mode_flat (mode_flat),
      .out_latch (out_latch),
      .alt_sel   (alt_sel),
      .alt_oe    (alt_oe),
      .alt_out   (alt_out),
      .pad_oe    (pad_oe),
      .pad_out   (pad_out)
   );

endmodule

// File: rtl/gpio_mux_ctrl_chk.sv
module gpio_mux_ctrl_chk
   import gpio_mux_pkg::*;
#(
   parameter int PIN_COUNT = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 5
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_req,
   input logic                        bus_wr,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic [DATA_W-1:0]           bus_wdata,
   input logic [DATA_W-1:0]           bus_rdata,
   input logic [PIN_COUNT-1:0]        pad_in,
   input logic [PIN_COUNT-1:0]        pad_oe,
   input logic [PIN_COUNT-1:0]        pad_out,
   input logic [PIN_COUNT-1:0]        alt_oe,
   input logic [PIN_COUNT-1:0]        alt_out,
   input logic [PIN_COUNT-1:0]        out_latch,
   input logic [PIN_COUNT-1:0]        alt_sel,
   input logic [MODE_W*PIN_COUNT-1:0] mode_flat
);

   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (out_latch == '0 && alt_sel == '0 && mode_flat == '0));

   assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_wr) |=> $stable(bus_rdata));

   assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_wr && bus_addr == ADDR_W'(OFF_SET)) |=>
      ((out_latch & $past(bus_wdata[PIN_COUNT-1:0])) == $past(bus_wdata[PIN_COUNT-1:0])));

   assert_clear_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_wr && bus_addr == ADDR_W'(OFF_CLR)) |=>
      ((out_latch & $past(bus_wdata[PIN_COUNT-1:0])) == '0));

   assert_input_path_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_wr && bus_addr == ADDR_W'(OFF_INPUT) && since_rst == 2'd3) |=>
      (bus_rdata[PIN_COUNT-1:0] == $past(pad_in, 3)));

   for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin_chk
      logic [MODE_W-1:0] m;
      assign m = mode_flat[MODE_W*p +: MODE_W];

      assert_input_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!alt_sel[p] && m == 2'd0) |-> (!pad_oe[p] && !pad_out[p]));

      assert_push_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!alt_sel[p] && m == 2'd1) |-> (pad_oe[p] && pad_out[p] == out_latch[p]));

      assert_open_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (!alt_sel[p] && m == 2'd2) |-> (!pad_out[p] && pad_oe[p] != out_latch[p]));

      assert_open_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (!alt_sel[p] && m == 2'd3) |-> (pad_out[p] && pad_oe[p] == out_latch[p]));

      assert_alt_override_R10: assert property (@(posedge clk) disable iff (!rst_n)
         alt_sel[p] |-> (pad_oe[p] == alt_oe[p] && pad_out[p] == alt_out[p]));
   end

endmodule

bind gpio_mux_ctrl gpio_mux_ctrl_chk #(
   .PIN_COUNT (PIN_COUNT),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_in    (pad_in),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out),
   .alt_oe    (alt_oe),
   .alt_out   (alt_out),
   .out_latch (out_latch),
   .alt_sel   (alt_sel),
   .mode_flat (mode_flat)
);

// File: tb/gpio_mux_ctrl_bench.sv
module gpio_mux_ctrl_bench;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [31:0] mode_lo;
      logic [31:0] mode_hi;
      logic [31:0] set_v;
      logic [31:0] clr_v;
      logic [31:0] exp_oe;
      logic [31:0] exp_out;
   } vec_t;

   // Modes (R6..R9) applied in sequence; the latch carries over between rows.
   localparam vec_t VECS [5] = '{
      '{32'h5555_5555, 32'h0000_0000, 32'h0000_A5A5, 32'h0000_0000, 32'h0000_FFFF, 32'h0000_A5A5},
      '{32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'h00FF_0000, 32'h0000_00F0, 32'h00FF_5AFA, 32'hFFFF_0000},
      '{32'h0000_0000, 32'h5555_5555, 32'h0000_0000, 32'h0000_FFFF, 32'hFFFF_0000, 32'h00FF_0000},
      '{32'h0000_00E4, 32'h0000_0000, 32'h0000_000A, 32'h0000_0000, 32'h0000_000E, 32'h0000_000A},
      '{32'h0000_00E4, 32'h0000_0000, 32'h0000_0000, 32'h0000_000A, 32'h0000_0006, 32'h0000_0008}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_oe;
   logic [31:0] pad_out;
   logic [31:0] alt_oe = '0;
   logic [31:0] alt_out = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_mux_ctrl u_gpio_mux_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_req   (bus_req),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_oe    (pad_oe),
      .pad_out   (pad_out),
      .alt_oe    (alt_oe),
      .alt_out   (alt_out)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 pad_oe", pad_oe, 32'h0);
      check("R1 pad_out", pad_out, 32'h0);
      bus_read(5'h0C, rd); check("R1 mode lo", rd, 32'h0);
      bus_read(5'h04, rd); check("R1 latch", rd, 32'h0);
      bus_read(5'h14, rd); check("R1 alt sel", rd, 32'h0);

      // Table of drive-mode vectors (R3, R4, R6, R7, R8, R9)
      foreach (VECS[i]) begin
         bus_write(5'h0C, VECS[i].mode_lo);
         bus_write(5'h10, VECS[i].mode_hi);
         bus_write(5'h04, VECS[i].set_v);
         bus_write(5'h08, VECS[i].clr_v);
         check($sformatf("R6/R7/R8/R9 oe vec%0d", i), pad_oe, VECS[i].exp_oe);
         check($sformatf("R6/R7/R8/R9 out vec%0d", i), pad_out, VECS[i].exp_out);
      end

      // R3 / R4: latch readback at both offsets
      bus_read(5'h04, rd); check("R3 latch via set", rd, 32'h00FF_0000);
      bus_read(5'h08, rd); check("R4 latch via clr", rd, 32'h00FF_0000);

      // R10: alternate function on pins 0 and 3
      alt_oe = 32'h0000_0001; alt_out = 32'h0000_0009;
      bus_write(5'h14, 32'h0000_0009);
      check("R10 oe", pad_oe, 32'h0000_0007);
      check("R10 out", pad_out, 32'h0000_0009);
      bus_read(5'h14, rd); check("R10 readback", rd, 32'h0000_0009);
      bus_read(5'h18, rd); check("R12 alt value view", rd, 32'h0000_0009);

      // R5: high mode word, pin16 push-pull, pin31 open-drain
      bus_write(5'h10, 32'h8000_0001);
      bus_read(5'h10, rd); check("R5 mode hi", rd, 32'h8000_0001);
      bus_read(5'h0C, rd); check("R5 mode lo", rd, 32'h0000_00E4);
      check("R5 oe", pad_oe, 32'h8001_0007);
      check("R5 out", pad_out, 32'h0001_0009);

      // R2: read data held across a write and idle cycles
      bus_read(5'h10, rd);
      bus_write(5'h04, 32'h0000_0000);
      @(negedge clk);
      check("R2 hold", bus_rdata, 32'h8000_0001);

      // R12: writes to read-only and unmapped offsets change nothing
      bus_write(5'h00, 32'hFFFF_FFFF);
      bus_write(5'h18, 32'hFFFF_FFFF);
      bus_write(5'h1C, 32'hFFFF_FFFF);
      check("R12 oe unchanged", pad_oe, 32'h8001_0007);
      check("R12 out unchanged", pad_out, 32'h0001_0009);
      bus_read(5'h04, rd); check("R12 latch unchanged", rd, 32'h00FF_0000);
      bus_read(5'h14, rd); check("R12 alt unchanged", rd, 32'h0000_0009);
      bus_read(5'h1C, rd); check("R12 unmapped read", rd, 32'h0);

      // R11: synchronizer depth
      pad_in = 32'h1234_5678;
      bus_read(5'h00, rd);
      bus_read(5'h00, rd); check("R11 one edge later", rd, 32'h0);
      bus_read(5'h00, rd); check("R11 two edges later", rd, 32'h1234_5678);
      pad_in = 32'hCAFE_0001;
      repeat (3) @(negedge clk);
      bus_read(5'h00, rd); check("R11 settled", rd, 32'hCAFE_0001);

      done = 1'b1;
      finish_run();
   end

endmodule